// File: doc/BRIEF.md
# Edge-Latched Bridge Interrupt Controller

This block collects up to 32 edge-triggered interrupt sources and merges them into one interrupt line for a parent controller. Each source is synchronised to the block clock. A rising edge on a synchronised source sets that source's bit in a pending (cause) register. The pending register is then gated by an enable (mask) register. The gated result drives the chained interrupt output. It also drives a priority encoder, which reports the highest-numbered pending, enabled source.

Software reaches the two registers through a simple single-cycle register port. The pending register records events whether or not the source is enabled. It is cleared by writing 0 to a bit; writing 1 leaves the bit as it was. For this reason a driver should clear a stale event before it enables that source. The number of sources is a parameter. Register bits above that count read as zero.

Top module: `edge_irq_bridge`

## Requirements
- R1: On synchronous active-low reset the pending register, the enable register and the `irq_out` output are all zero.
- R2: A rising edge on `src_in[i]` sets pending bit i. The bit reads 1 at the third rising clock edge after the input changes: two synchroniser stages and one latch stage. A source held high, or a falling source, does not set the bit again.
- R3: A pending bit is set whether its enable bit is 0 or 1.
- R4: A write to offset 0x0 (pending register) clears every pending bit written as 0 and leaves every bit written as 1 unchanged.
- R5: Offset 0x4 is the enable register. A write stores `reg_wdata[NUM_SRC-1:0]`, and a read returns the stored value. Bits at and above NUM_SRC read as zero in both registers.
- R6: `irq_out` is 1 exactly when some bit of (pending AND enable) is 1.
- R7: `pend_idx` gives the highest-numbered set bit of (pending AND enable), and `pend_valid` is 1 exactly when such a bit exists. When `pend_valid` is 0, `pend_idx` is 0.
- R8: If a new edge on source i and a write that clears bit i occur in the same clock cycle, bit i stays set.
- R9: Reads of any offset other than 0x0 and 0x4 return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NUM_SRC | Asynchronous edge-triggered interrupt sources |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_out | output | 1 | Chained interrupt toward the parent controller |
| pend_idx | output | IDX_W | Highest pending enabled source number |
| pend_valid | output | 1 | `pend_idx` is meaningful |

## Verification
A detected source edge and a software write to the pending register can act on the same bit in the same cycle. The outcome depends on which of them the register update favours. The bench raises a source, counts two clock edges so that the edge pulse is live, and issues a zero-write to that bit so that it lands on the same edge as the latch. It then reads the register back and expects the bit to remain set. A second check clears the bit when no edge is in flight and confirms that the clear takes effect.

// File: rtl/irqb_pkg.sv
// Package: shared constants for the edge-latched bridge interrupt controller.
// Assumes a byte-addressed register port with 32-bit registers.
package irqb_pkg;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned ADDR_W     = 4;
    localparam logic [ADDR_W-1:0] OFF_PEND = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_ENAB = 4'h4;
endpackage

// File: rtl/irqb_edge_detect.sv
// Module: synchronises asynchronous sources and produces one-cycle rising-edge pulses.
// Assumes each source stays high for at least SYNC_STAGES+1 clock cycles to be seen.
module irqb_edge_detect #(
    parameter int unsigned NUM_SRC     = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_async,
    output logic [NUM_SRC-1:0] rise_pulse
);
    logic [NUM_SRC-1:0] sync_q [SYNC_STAGES];
    logic [NUM_SRC-1:0] prev_q;

    // Purpose: shift each source through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
        end else begin
            sync_q[0] <= src_async;
            for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
        end
    end

    // Purpose: keep a one-cycle delayed copy of the synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    // Purpose: flag a low-to-high transition of the synchronised level.
    always_comb rise_pulse = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/irqb_regs.sv
// Module: pending and enable registers with write-zero-to-clear pending access.
// Assumes a single-cycle write strobe; when an edge and a clear meet, the edge wins.
module irqb_regs
    import irqb_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] rise_pulse,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [NUM_SRC-1:0] pend_q,
    output logic [NUM_SRC-1:0] enab_q
);
    logic               wr_pend;
    logic               wr_enab;
    logic [NUM_SRC-1:0] keep_mask;

    // Purpose: decode the write strobes of the two registers.
    always_comb begin
        wr_pend   = reg_wr && (reg_addr == OFF_PEND);
        wr_enab   = reg_wr && (reg_addr == OFF_ENAB);
        keep_mask = wr_pend ? reg_wdata[NUM_SRC-1:0] : {NUM_SRC{1'b1}};
    end

    // Purpose: latch edges and apply zero-written clears, with the edge taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & keep_mask) | rise_pulse;
    end

    // Purpose: store the enable register on a write to its offset.
    always_ff @(posedge clk) begin
        if (!rst_n)       enab_q <= '0;
        else if (wr_enab) enab_q <= reg_wdata[NUM_SRC-1:0];
    end

    // Purpose: return the addressed register, zero-extended, or zero for other offsets.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_PEND: reg_rdata[NUM_SRC-1:0] = pend_q;
            OFF_ENAB: reg_rdata[NUM_SRC-1:0] = enab_q;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqb_prio_enc.sv
// Module: finds the highest-numbered set bit of a request vector.
// Assumes index 0 is reported when no request is set.
module irqb_prio_enc #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned IDX_W   = 5
) (
    input  logic [NUM_SRC-1:0] req,
    output logic [IDX_W-1:0]   top_idx,
    output logic               any_req
);
    // Purpose: scan upward so that the last set bit found is the highest.
    always_comb begin
        top_idx = '0;
        any_req = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i]) begin
                top_idx = IDX_W'(i);
                any_req = 1'b1;
            end
        end
    end
endmodule

// File: rtl/edge_irq_bridge.sv
// Module: top of the edge-latched bridge interrupt controller.
// Assumes NUM_SRC is between 1 and 32 and that software clears a stale event before enabling it.
module edge_irq_bridge
    import irqb_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 32,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_out,
    output logic [IDX_W-1:0]   pend_idx,
    output logic               pend_valid
);
    logic [NUM_SRC-1:0] rise_pulse;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] enab_q;
    logic [NUM_SRC-1:0] live_req;

    irqb_edge_detect #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_async (src_in),
        .rise_pulse(rise_pulse)
    );

    irqb_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_pulse(rise_pulse),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pend_q    (pend_q),
        .enab_q    (enab_q)
    );

    // Purpose: gate pending events with the enable register.
    always_comb live_req = pend_q & enab_q;

    irqb_prio_enc #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_prio (
        .req    (live_req),
        .top_idx(pend_idx),
        .any_req(pend_valid)
    );

    // Purpose: drive the chained interrupt from any enabled pending event.
    always_comb irq_out = |live_req;
endmodule

// File: rtl/edge_irq_bridge_chk.sv
// Module: assertion checker for edge_irq_bridge, attached by bind.
// Assumes the internal names rise_pulse, pend_q and enab_q of the top module.
module edge_irq_bridge_chk
    import irqb_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned IDX_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] rise_pulse,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] enab_q,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               reg_wr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic               irq_out,
    input logic [IDX_W-1:0]   pend_idx,
    input logic               pend_valid
);
    logic [NUM_SRC-1:0] live;
    always_comb live = pend_q & enab_q;

    // R1: registers are zero after a reset edge
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0 && enab_q == '0));

    // R2, R3, R8: every edge pulse leaves its bit set, mask or write notwithstanding
    p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_pulse) |=> ((pend_q & $past(rise_pulse)) == $past(rise_pulse)));

    // R4: a bit written 0 with no edge reads 0 afterwards
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_PEND) |=>
        ((pend_q & ~$past(reg_wdata[NUM_SRC-1:0]) & ~$past(rise_pulse)) == '0));

    // R5: the enable register takes the written value
    p_enab_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_ENAB) |=> (enab_q == $past(reg_wdata[NUM_SRC-1:0])));

    // R9: writes elsewhere leave the enable register unchanged
    p_other_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr != OFF_ENAB) |=> $stable(enab_q));

    // R6: the chained output agrees with the encoder and the gated state
    p_irq_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (pend_valid && live[pend_idx]));

    // R7: no enabled pending bit lies above the reported index
    p_idx_highest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> ((live >> pend_idx) == NUM_SRC'(1)));

    // R7: an idle encoder reports index zero
    p_idx_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_valid |-> (pend_idx == '0 && !irq_out));
endmodule

bind edge_irq_bridge edge_irq_bridge_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_pulse(rise_pulse),
    .pend_q    (pend_q),
    .enab_q    (enab_q),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .irq_out   (irq_out),
    .pend_idx  (pend_idx),
    .pend_valid(pend_valid)
);

// File: tb/test_edge_irq_bridge.sv
// Bench: table-driven pattern walk followed by directed reset and corner tests.
module test_edge_irq_bridge;
    localparam int NSRC = 32;
    localparam int IW   = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_in = '0;
    logic [3:0]      reg_addr = '0;
    logic            reg_wr = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            irq_out;
    logic [IW-1:0]   pend_idx;
    logic            pend_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    edge_irq_bridge #(.NUM_SRC(NSRC)) i_edge_irq_bridge (
        .clk, .rst_n, .src_in, .reg_addr, .reg_wr, .reg_wdata,
        .reg_rdata, .irq_out, .pend_idx, .pend_valid
    );

    // Vector: {source pattern, enable, expected pending, expected valid, expected index}
    localparam int NVEC = 6;
    localparam logic [101:0] VEC [NVEC] = '{
        {32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 1'b1, 5'd0},
        {32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 1'b0, 5'd0},
        {32'h8000_0010, 32'hFFFF_FFFF, 32'h8000_0010, 1'b1, 5'd31},
        {32'h00F0_0000, 32'h0030_0000, 32'h00F0_0000, 1'b1, 5'd21},
        {32'h1234_5678, 32'h0000_FF00, 32'h1234_5678, 1'b1, 5'd14},
        {32'hA5A5_0000, 32'h0000_FFFF, 32'hA5A5_0000, 1'b0, 5'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin : watchdog
        #(200000 * 20);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rv;
        settle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(4'h0, rv); check("R1 pending", rv, 32'h0);
        rd(4'h4, rv); check("R1 enable", rv, 32'h0);
        check("R1 irq", {31'b0, irq_out}, 32'h0);

        // Table walk: R3, R5, R6, R7
        for (int v = 0; v < NVEC; v++) begin
            src_in = '0;
            settle(4);
            wr(4'h0, 32'h0);
            wr(4'h4, VEC[v][69:38]);
            src_in = VEC[v][101:70];
            settle(4);
            rd(4'h0, rv); check("R3 pending", rv, VEC[v][37:6]);
            rd(4'h4, rv); check("R5 enable", rv, VEC[v][69:38]);
            check("R6 irq", {31'b0, irq_out}, {31'b0, VEC[v][5]});
            check("R7 valid", {31'b0, pend_valid}, {31'b0, VEC[v][5]});
            check("R7 index", {27'b0, pend_idx}, {27'b0, VEC[v][4:0]});
        end

        // R2: held-high source does not set again after a clear
        wr(4'h0, 32'h0);
        settle(4);
        rd(4'h0, rv); check("R2 held high", rv, 32'h0);
        // R2: falling source does not set
        src_in = '0;
        settle(4);
        rd(4'h0, rv); check("R2 falling", rv, 32'h0);

        // R2: latency of three clock edges
        src_in = 32'h0000_0100;
        settle(2);
        rd(4'h0, rv); check("R2 not yet", rv, 32'h0);
        settle(1);
        rd(4'h0, rv); check("R2 latched", rv, 32'h0000_0100);

        // R4: only zero-written bits clear
        src_in = 32'h0000_0300;
        settle(4);
        wr(4'h0, 32'hFFFF_FEFF);
        rd(4'h0, rv); check("R4 partial clear", rv, 32'h0000_0200);
        wr(4'h0, 32'h0);
        rd(4'h0, rv); check("R4 full clear", rv, 32'h0);

        // R8: edge and clear in the same cycle, edge wins
        src_in = '0;
        settle(4);
        src_in = 32'h0000_0004;
        settle(2);
        wr(4'h0, 32'h0);
        rd(4'h0, rv); check("R8 edge wins", rv, 32'h0000_0004);
        wr(4'h0, 32'h0);
        rd(4'h0, rv); check("R8 later clear", rv, 32'h0);

        // R9: unused offsets
        wr(4'h4, 32'h0000_00F0);
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h4, rv); check("R9 enable kept", rv, 32'h0000_00F0);
        rd(4'h8, rv); check("R9 read zero", rv, 32'h0);

        // R1: reset mid-run clears state
        src_in = 32'h0000_00F0;
        settle(4);
        check("R6 irq before reset", {31'b0, irq_out}, 32'h1);
        rst_n = 1'b0;
        settle(2);
        rst_n = 1'b1;
        src_in = '0;
        #1;
        rd(4'h0, rv); check("R1 pending after reset", rv, 32'h0);
        rd(4'h4, rv); check("R1 enable after reset", rv, 32'h0);
        check("R1 irq after reset", {31'b0, irq_out}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule